// File: doc/BRIEF.md
# Iterative Integer Divider

A sequential shift-subtract divider that turns a double-width dividend and a single-width divisor into a single-width quotient and remainder, retiring one quotient bit per clock. It takes four operating modes, chosen by two mode inputs: a wide divide (2W-bit dividend) or a narrow divide (W-bit dividend), each either signed (two's complement) or unsigned. The wide dividend arrives as one 2W-bit word whose upper half is the high word of an aligned pair.

An operation starts with a one-cycle `start_i` pulse, which carries the operands and the mode. The unit then shows `busy_o` for exactly W cycles and marks the result with a one-cycle `done_o` pulse. Quotient, remainder and the two flags stay valid after `done_o` until the next operation is accepted. Signed operands are handled as magnitudes and the signs are applied at the end. The latency does not depend on the mode, because the iteration count is tied to the divisor width.

Top module: `int_divider`

## Requirements
- R1: After reset `busy_o`, `done_o`, `quotient_o`, `remainder_o`, `div_zero_o` and `overflow_o` are all 0.
- R2: Unsigned mode (`signed_i`=0) returns the truncated quotient and the remainder of the unsigned operands whenever the quotient fits in W bits.
- R3: A divisor of zero sets `div_zero_o` at `done_o`. In that case quotient, remainder and `overflow_o` are don't-care.
- R4: Signed mode (`signed_i`=1) truncates the quotient toward zero, negating it when the operand signs differ. The remainder carries the sign of the dividend, and dividend = quotient*divisor + remainder.
- R5: With a nonzero divisor, `overflow_o` is 1 exactly when the true quotient lies outside the W-bit range of the mode: 0..2^W-1 when unsigned, -2^(W-1)..2^(W-1)-1 when signed. When it is 1, quotient and remainder are don't-care.
- R6: `done_o` rises exactly W clock edges after the edge that samples `start_i`, and the latency is the same for all four modes.
- R7: `busy_o` is 1 from the accepting edge until `done_o` rises, and `busy_o` and `done_o` are never 1 together.
- R8: `done_o` is a single-cycle pulse, and the results stay unchanged after it until the next accepted start.
- R9: A `start_i` pulse that arrives while `busy_o` is 1 is ignored, and the running operation completes with its original operands.
- R10: Narrow mode (`wide_i`=0) uses only `dividend_i[W-1:0]`, sign-extended when signed and zero-extended when unsigned. The upper half of `dividend_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| wide_i | input | 1 | 1: 2W/W divide, 0: W/W divide |
| signed_i | input | 1 | 1: two's-complement operands |
| dividend_i | input | 2W | Dividend (high word in upper half) |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Quotient out of range |

## Verification
The bench builds the divider with W=4, so the dividend is 8 bits and the divisor is 4 bits. At this size every wide dividend can be run against every divisor in both signed and unsigned mode, and every narrow dividend can be run against every divisor with a varying upper half. The sweep therefore covers each signed overflow boundary, the most-negative operands, the zero divisor and the exact latency of every operation. Since the reference values come from plain integer arithmetic in the bench, each result is checked against real arithmetic and not against a model of the algorithm.

// File: rtl/int_divider_pkg.sv
package int_divider_pkg;
  typedef struct packed {
    logic sgn;    // signed operation
    logic neg_q;  // quotient to be negated
    logic neg_r;  // remainder to be negated
    logic ovf;    // magnitude quotient exceeds W bits
    logic dz;     // zero divisor
  } div_ctx_t;
endpackage

// File: rtl/int_divider_prep.sv
module int_divider_prep
  import int_divider_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           wide_i,
  input  logic           signed_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [W-1:0]   hi_mag_o,
  output logic [W-1:0]   lo_mag_o,
  output logic [W-1:0]   div_mag_o,
  output div_ctx_t       ctx_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] ext;
  logic [DW-1:0] dvd_mag;
  logic          dvd_neg;
  logic          dsr_neg;

  always_comb begin
    ext       = wide_i ? dividend_i
                       : {{W{signed_i & dividend_i[W-1]}}, dividend_i[W-1:0]};
    dvd_neg   = signed_i & ext[DW-1];
    dsr_neg   = signed_i & divisor_i[W-1];
    dvd_mag   = dvd_neg ? (~ext + 1'b1) : ext;
    div_mag_o = dsr_neg ? (~divisor_i + 1'b1) : divisor_i;
    hi_mag_o  = dvd_mag[DW-1:W];
    lo_mag_o  = dvd_mag[W-1:0];
    ctx_o.sgn   = signed_i;
    ctx_o.neg_q = dvd_neg ^ dsr_neg;
    ctx_o.neg_r = dvd_neg;
    ctx_o.dz    = (divisor_i == '0);
    ctx_o.ovf   = (dvd_mag[DW-1:W] >= div_mag_o);
  end
endmodule

// File: rtl/int_divider_core.sv
module int_divider_core
  import int_divider_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] hi_mag_i,
  input  logic [W-1:0] lo_mag_i,
  input  logic [W-1:0] div_mag_i,
  input  div_ctx_t     ctx_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] q_mag_o,
  output logic [W-1:0] r_mag_o,
  output div_ctx_t     ctx_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITER = CW'(W);

  logic [W-1:0]  rem_q, acc_q, div_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  div_ctx_t      ctx_q;

  logic [W:0]    trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem_q, acc_q[W-1]};
    diff  = trial - {1'b0, div_q};
    ge    = (trial >= {1'b0, div_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      acc_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ctx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          rem_q  <= hi_mag_i;
          acc_q  <= lo_mag_i;
          div_q  <= div_mag_i;
          ctx_q  <= ctx_i;
          cnt_q  <= ITER;
          busy_q <= 1'b1;
        end
      end else begin
        rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
        acc_q <= {acc_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign q_mag_o = acc_q;
  assign r_mag_o = rem_q;
  assign ctx_o   = ctx_q;

  p_busy_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_last_iter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == CW'(1)) |=> done_q);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(div_q) && $stable(ctx_q)));
  p_rem_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !ctx_q.ovf && !ctx_q.dz) |-> (rem_q < div_q));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i && !done_q) |=> ($stable(acc_q) && $stable(rem_q)));
endmodule

// File: rtl/int_divider_fix.sv
module int_divider_fix
  import int_divider_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] q_mag_i,
  input  logic [W-1:0] r_mag_i,
  input  div_ctx_t     ctx_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         overflow_o,
  output logic         div_zero_o
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic sgn_ovf;

  always_comb begin
    quotient_o  = ctx_i.neg_q ? (~q_mag_i + 1'b1) : q_mag_i;
    remainder_o = ctx_i.neg_r ? (~r_mag_i + 1'b1) : r_mag_i;
    sgn_ovf     = ctx_i.sgn & (ctx_i.neg_q ? (q_mag_i > HALF) : (q_mag_i >= HALF));
    overflow_o  = ctx_i.ovf | sgn_ovf;
    div_zero_o  = ctx_i.dz;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import int_divider_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           wide_i,
  input  logic           signed_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   quotient_o,
  output logic [W-1:0]   remainder_o,
  output logic           div_zero_o,
  output logic           overflow_o
);
  logic [W-1:0] hi_mag, lo_mag, div_mag, q_mag, r_mag;
  div_ctx_t     ctx_in, ctx_run;

  int_divider_prep #(.W(W)) u_prep (
    .wide_i(wide_i), .signed_i(signed_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .hi_mag_o(hi_mag), .lo_mag_o(lo_mag),
    .div_mag_o(div_mag), .ctx_o(ctx_in)
  );

  int_divider_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .hi_mag_i(hi_mag), .lo_mag_i(lo_mag), .div_mag_i(div_mag), .ctx_i(ctx_in),
    .busy_o(busy_o), .done_o(done_o), .q_mag_o(q_mag), .r_mag_o(r_mag),
    .ctx_o(ctx_run)
  );

  int_divider_fix #(.W(W)) u_fix (
    .q_mag_i(q_mag), .r_mag_i(r_mag), .ctx_i(ctx_run),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .overflow_o(overflow_o), .div_zero_o(div_zero_o)
  );

  p_zero_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (div_zero_o == ($past(divisor_i) == '0)));
  p_rem_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o && !overflow_o && ctx_run.neg_r && remainder_o != '0)
      |-> remainder_o[W-1]);
endmodule

// File: tb/int_divider_tb.sv
module int_divider_tb;
  localparam int W  = 4;
  localparam int DW = 2 * W;
  localparam int MASK = (1 << W) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          wide_i = 1'b0;
  logic          signed_i = 1'b0;
  logic [DW-1:0] dividend_i = '0;
  logic [W-1:0]  divisor_i = '0;
  logic          busy_o, done_o, div_zero_o, overflow_o;
  logic [W-1:0]  quotient_o, remainder_o;

  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  int_divider #(.W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wide_i(wide_i),
    .signed_i(signed_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .quotient_o(quotient_o),
    .remainder_o(remainder_o), .div_zero_o(div_zero_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // run one divide and compare with integer arithmetic
  task automatic run_op(input bit wide, input bit sgn, input logic [DW-1:0] dvd,
                        input logic [W-1:0] dsr, input bit intrude);
    int a, b, q, r;
    bit ovf;
    if (wide) a = sgn ? int'($signed(dvd)) : int'(dvd);
    else      a = sgn ? int'($signed(dvd[W-1:0])) : int'(dvd[W-1:0]);
    b = sgn ? int'($signed(dsr)) : int'(dsr);
    @(negedge clk_i);
    wide_i = wide; signed_i = sgn; dividend_i = dvd; divisor_i = dsr; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7 busy after start", int'(busy_o), 1);
    if (intrude) begin
      // R9: second start while busy with other operands
      start_i = 1'b1; dividend_i = ~dvd; divisor_i = dsr + 1'b1; wide_i = ~wide;
    end
    for (int i = 0; i < W - 1; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) begin
        chk("R6 done early", int'(done_o), 0);
      end
    end
    chk("R7 busy until last iteration", int'(busy_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 done after W edges", int'(done_o), 1);
    chk("R7 busy low at done", int'(busy_o), 0);
    if (b == 0) begin
      chk("R3 div zero flag", int'(div_zero_o), 1);
    end else begin
      chk("R3 no div zero flag", int'(div_zero_o), 0);
      q = a / b;
      r = a % b;
      ovf = sgn ? (q < -(1 << (W-1)) || q > (1 << (W-1)) - 1) : (q > MASK);
      chk(sgn ? "R5 signed overflow" : "R5 unsigned overflow", int'(overflow_o), int'(ovf));
      if (!ovf) begin
        chk(sgn ? (wide ? "R4 quotient" : "R10 R4 quotient") : (wide ? "R2 quotient" : "R10 R2 quotient"),
            int'(quotient_o), q & MASK);
        chk(sgn ? "R4 remainder" : "R2 remainder", int'(remainder_o), r & MASK);
      end
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] q_hold, r_hold;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 quotient", int'(quotient_o), 0);
    chk("R1 remainder", int'(remainder_o), 0);
    chk("R1 flags", int'({div_zero_o, overflow_o}), 0);
    rst_ni = 1'b1;

    // wide sweeps, both signedness
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < (1 << DW); d++)
        for (int v = 0; v < (1 << W); v++)
          run_op(1'b1, s[0], DW'(d), W'(v), 1'b0);

    // narrow sweeps with varying upper half (R10)
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < (1 << W); d++)
        for (int v = 0; v < (1 << W); v++)
          run_op(1'b0, s[0], {W'(d * 5 + v), W'(d)}, W'(v), 1'b0);

    // starts while busy must be ignored (R9)
    run_op(1'b1, 1'b0, 8'd100, 4'd7, 1'b1);
    run_op(1'b1, 1'b1, 8'hC3, 4'h5, 1'b1);
    run_op(1'b0, 1'b1, 8'h0A, 4'hD, 1'b1);

    // results hold after done (R8)
    run_op(1'b1, 1'b0, 8'd77, 4'd9, 1'b0);
    q_hold = quotient_o; r_hold = remainder_o;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 done single pulse", int'(done_o), 0);
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 quotient held", int'(quotient_o), int'(q_hold));
    chk("R8 remainder held", int'(remainder_o), int'(r_hold));
    chk("R8 quotient value", int'(q_hold), 77 / 9);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule